// File: doc/BRIEF.md
# Dual-Mode Write Protection Controller

This block sits between the command decoder of a serial nonvolatile memory and its internal write engine. It decides whether a requested write may go ahead. Writes to the main array are checked against one of two schemes. The legacy scheme uses a two-bit block-protect field that covers the upper quarter, the upper half or the whole array. The enhanced scheme uses up to four partitions, each with its own end address and inhibit bit. A mode bit in the status register selects the scheme.

A separate security area holds a 16-byte read-only serial number followed by 256 user bytes. A lock command can close the user bytes for good. The active-low write-protect pin blocks changes to the status and partition registers. Every rejected request is silently dropped.

Requests arrive on a valid/ready stream that never pushes back. `req_ready` is held high, so every cycle with `req_valid` high is one accepted request. An allowed array or security write comes out as a one-cycle `wr_go` pulse in the cycle after acceptance. That pulse is the start of the internal write cycle.

Top module: `wprot_ctrl`

## Requirements
- R1: After reset, the mode is legacy (0), the block-protect field is 00, the security page is unlocked, every partition end is the all-ones address with its inhibit bit clear, and `wr_go` is low.
- R2: `req_ready` is always high. An allowed write accepted at a clock edge makes `wr_go` high for exactly the following cycle, with `wr_addr` equal to the request address and `wr_sec` set for a security write.
- R3: In legacy mode, array writes are protected by the block-protect field `bp` as follows: 00 protects nothing, 01 protects addresses whose top two bits are 11, 10 protects addresses whose top bit is 1, and 11 protects every address.
- R4: A request of kind 1 (status) loads `bp` from `req_data[1:0]` and the mode from `req_data[2]` (0 legacy, 1 enhanced). The new values govern requests from the next cycle on.
- R5: A request of kind 2 (partition) writes the partition selected by `req_addr[1:0]`. It loads the end address from `req_data[AW-1:0]` and the inhibit bit from `req_data[AW]`. In enhanced mode an array address belongs to the lowest-index partition whose end is not below it, and it is protected when that partition's inhibit bit is set. An address above every end is writable.
- R6: The mode bit alone picks the scheme. In enhanced mode `bp` has no effect, and in legacy mode the partition inhibit bits have no effect.
- R7: While `wp_n` is low, status and partition requests are dropped. Array and security writes are not affected by the pin.
- R8: A security write (kind 3) to an address below 16 is always rejected, as is one to 272 or above. An address from 16 to 271 is allowed while unlocked. Array protection does not apply to security writes.
- R9: A lock request (kind 4) sets the lock. No request clears it, and while it is set every security write is rejected.
- R10: Rejected writes, status, partition and lock requests, and request kinds 5 to 7 never produce `wr_go`. Kinds 0 (array) and 3 (security) are the only ones that can.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, constant high |
| req_kind | input | 3 | 0 array, 1 status, 2 partition, 3 security, 4 lock |
| req_addr | input | AW | Array address, security offset or partition index |
| req_data | input | AW+1 | Register payload for status and partition requests |
| wr_go | output | 1 | One-cycle start of an internal write |
| wr_sec | output | 1 | The started write targets the security area |
| wr_addr | output | AW | Address of the started write |
| mode_o | output | 1 | Current protection mode |
| bp_o | output | 2 | Current block-protect field |
| locked_o | output | 1 | Security page lock |

## Verification
The bench goes after the legacy boundaries at 0x3FFFF/0x40000 and 0x5FFFF/0x60000. A comparator off by one there would allow the first protected byte or block the last free one. In enhanced mode it checks the partition edges and the region above the last end. A design that picked the last matching partition instead of the first, or that treated that region as protected, would produce `wr_go` at the wrong addresses. It then toggles `wp_n` around register writes, checks that `bp` is ignored in enhanced mode, probes the serial bytes and the 16/271/272 security limits, and checks that the lock survives later requests. A leaky gate would show up as a changed `mode_o`/`bp_o`/`locked_o` or as a stray `wr_go`.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  typedef enum logic [2:0] {
    K_ARRAY  = 3'd0,
    K_STATUS = 3'd1,
    K_PART   = 3'd2,
    K_SEC    = 3'd3,
    K_LOCK   = 3'd4
  } req_kind_e;

  localparam int SERIAL_BYTES = 16;
  localparam int USER_BYTES   = 256;
  localparam int SEC_END      = SERIAL_BYTES + USER_BYTES;
endpackage

// File: rtl/wprot_legacy.sv
module wprot_legacy #(
  parameter int AW = 19
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    bp,
  output logic          prot
);
  always_comb begin
    unique case (bp)
      2'b00:   prot = 1'b0;
      2'b01:   prot = (addr[AW-1:AW-2] == 2'b11);
      2'b10:   prot = addr[AW-1];
      default: prot = 1'b1;
    endcase
  end
endmodule

// File: rtl/wprot_partition.sv
module wprot_partition #(
  parameter int AW    = 19,
  parameter int NPART = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NPART)-1:0] wr_idx,
  input  logic [AW-1:0]            wr_end,
  input  logic                     wr_inh,
  input  logic [AW-1:0]            addr,
  output logic                     prot
);
  localparam int IW = $clog2(NPART);

  logic [AW-1:0] end_q [NPART];
  logic          inh_q [NPART];
  logic [NPART-1:0] hit;

  for (genvar i = 0; i < NPART; i++) begin : g_part
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        end_q[i] <= '1;
        inh_q[i] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(i)) begin
        end_q[i] <= wr_end;
        inh_q[i] <= wr_inh;
      end
    end
    assign hit[i] = (addr <= end_q[i]);
  end

  always_comb begin
    prot = 1'b0;
    for (int i = NPART - 1; i >= 0; i--) begin
      if (hit[i]) prot = inh_q[i];
    end
  end

  // R5: the lowest-index partition wins
  a_r5_first_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (addr <= end_q[0]) |-> (prot == inh_q[0]));
endmodule

// File: rtl/wprot_secpage.sv
module wprot_secpage #(
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_req,
  input  logic [AW-1:0] addr,
  output logic          allow,
  output logic          locked
);
  import wprot_pkg::*;
  localparam logic [AW-1:0] USER_LO = AW'(SERIAL_BYTES);
  localparam logic [AW-1:0] USER_HI = AW'(SEC_END - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        locked <= 1'b0;
    else if (lock_req) locked <= 1'b1;
  end

  assign allow = !locked && (addr >= USER_LO) && (addr <= USER_HI);

  // R9: the lock never falls once set
  a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int AW    = 19,
  parameter int NPART = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wp_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [2:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [AW:0]   req_data,
  output logic          wr_go,
  output logic          wr_sec,
  output logic [AW-1:0] wr_addr,
  output logic          mode_o,
  output logic [1:0]    bp_o,
  output logic          locked_o
);
  import wprot_pkg::*;
  localparam int IW = $clog2(NPART);

  req_kind_e kind;
  logic      mode_q;
  logic [1:0] bp_q;
  logic      leg_prot, part_prot, sec_ok, arr_ok;
  logic      stat_we, part_we, go_d, is_arr, is_sec;

  assign kind      = req_kind_e'(req_kind);
  assign req_ready = 1'b1;
  assign stat_we   = req_valid && kind == K_STATUS && wp_n;
  assign part_we   = req_valid && kind == K_PART && wp_n;
  assign is_arr    = req_valid && kind == K_ARRAY;
  assign is_sec    = req_valid && kind == K_SEC;

  wprot_legacy #(.AW(AW)) u_leg (
    .addr(req_addr), .bp(bp_q), .prot(leg_prot)
  );

  wprot_partition #(.AW(AW), .NPART(NPART)) u_part (
    .clk(clk), .rst_n(rst_n), .wr_en(part_we),
    .wr_idx(req_addr[IW-1:0]), .wr_end(req_data[AW-1:0]),
    .wr_inh(req_data[AW]), .addr(req_addr), .prot(part_prot)
  );

  wprot_secpage #(.AW(AW)) u_sec (
    .clk(clk), .rst_n(rst_n), .lock_req(req_valid && kind == K_LOCK),
    .addr(req_addr), .allow(sec_ok), .locked(locked_o)
  );

  assign arr_ok = mode_q ? !part_prot : !leg_prot;
  assign go_d   = (is_arr && arr_ok) || (is_sec && sec_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      bp_q   <= 2'b00;
    end else if (stat_we) begin
      mode_q <= req_data[2];
      bp_q   <= req_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_go   <= 1'b0;
      wr_sec  <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_go <= go_d;
      if (go_d) begin
        wr_sec  <= is_sec;
        wr_addr <= req_addr;
      end
    end
  end

  assign mode_o = mode_q;
  assign bp_o   = bp_q;

  // R2: no back-pressure
  a_r2_ready: assert property (@(posedge clk) disable iff (!rst_n) req_ready);
  // R10: a start pulse always follows a request
  a_r10_go_from_req: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(req_valid));
  // R7: status bits hold while the pin is low
  a_r7_wp_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_n && req_valid && kind == K_STATUS) |=> ($stable(mode_q) && $stable(bp_q)));
  // R3: legacy full protection blocks every array write
  a_r3_all_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (is_arr && !mode_q && bp_q == 2'b11) |=> !wr_go);
  // R8: serial-number bytes never start a write
  a_r8_serial_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sec && req_addr < AW'(SERIAL_BYTES)) |=> !wr_go);
endmodule

// File: tb/wprot_ctrl_test.sv
module wprot_ctrl_test;
  localparam int AW = 19;
  localparam int CLK_PERIOD = 10;
  localparam int TOP = (1 << AW) - 1;

  logic clk = 0, rst_n = 0, wp_n = 1, req_valid = 0;
  logic req_ready, wr_go, wr_sec, mode_o, locked_o;
  logic [2:0] req_kind = 0;
  logic [AW-1:0] req_addr = 0, wr_addr;
  logic [AW:0] req_data = 0;
  logic [1:0] bp_o;

  wprot_ctrl #(.AW(AW), .NPART(4)) uut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_addr(req_addr),
    .req_data(req_data), .wr_go(wr_go), .wr_sec(wr_sec), .wr_addr(wr_addr),
    .mode_o(mode_o), .bp_o(bp_o), .locked_o(locked_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_mode, m_bp, m_lock, m_end[4], m_inh[4];
  int e_go, e_sec, e_addr;
  bit started = 0;
  int vectors = 0, errors = 0, cycles = 0;
  string tag = "R1";

  function automatic int arr_allowed(int a);
    if (m_mode == 1) begin
      for (int i = 0; i < 4; i++) if (a <= m_end[i]) return (m_inh[i] == 0);
      return 1;
    end
    case (m_bp)
      0: return 1;
      1: return (a < (TOP + 1) / 4 * 3);
      2: return (a < (TOP + 1) / 2);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (!rst_n) begin
      m_mode = 0; m_bp = 0; m_lock = 0; e_go = 0; e_sec = 0; e_addr = 0;
      for (int i = 0; i < 4; i++) begin m_end[i] = TOP; m_inh[i] = 0; end
    end else begin
      int a, ok;
      a = int'(req_addr); ok = 0;
      if (req_valid) begin
        case (int'(req_kind))
          0: ok = arr_allowed(a);
          1: if (wp_n) begin m_bp = int'(req_data[1:0]); m_mode = int'(req_data[2]); end
          2: if (wp_n) begin
               m_end[a % 4] = int'(req_data[AW-1:0]); m_inh[a % 4] = int'(req_data[AW]);
             end
          3: ok = (m_lock == 0 && a >= 16 && a < 272);
          4: m_lock = 1;
          default: ok = 0;
        endcase
      end
      e_go = ok;
      if (ok) begin e_addr = a; e_sec = (int'(req_kind) == 3); end
    end
  end

  task automatic chk(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("req_ready", int'(req_ready), 1);
      chk("wr_go", int'(wr_go), e_go);
      chk("mode", int'(mode_o), m_mode);
      chk("bp", int'(bp_o), m_bp);
      chk("locked", int'(locked_o), m_lock);
      if (e_go == 1) begin
        chk("wr_addr", int'(wr_addr), e_addr);
        chk("wr_sec", int'(wr_sec), e_sec);
      end
    end
  end

  task automatic rq(int k, int a, int d = 0);
    @(negedge clk);
    req_valid = 1; req_kind = 3'(k); req_addr = AW'(a); req_data = (AW+1)'(d);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic part(int idx, int e, int inh);
    rq(2, idx, (inh << AW) | e);
  endtask

  bit done = 0;
  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lf;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    tag = "R3"; // bp 00: nothing protected; also R2 address/sec reporting
    rq(0, 0); rq(0, TOP); rq(0, 'h40000);
    tag = "R4";
    rq(1, 0, 1);
    tag = "R3";
    rq(0, 'h5FFFF); rq(0, 'h60000); rq(0, TOP);
    rq(1, 0, 2);
    rq(0, 'h3FFFF); rq(0, 'h40000);
    rq(1, 0, 3);
    rq(0, 0); rq(0, 'h12345);
    tag = "R7";
    wp_n = 0; rq(1, 0, 0); rq(0, 0); wp_n = 1;
    tag = "R5";
    part(0, 'h0FFFF, 0); part(1, 'h3FFFF, 1); part(2, 'h5FFFF, 0); part(3, 'h6FFFF, 1);
    tag = "R6";
    rq(1, 0, 0); rq(0, 'h20000); rq(0, 'h65000);
    rq(1, 0, 4 | 3);
    rq(0, 0); rq(0, 'h40000);
    tag = "R5";
    rq(0, 'h0FFFF); rq(0, 'h10000); rq(0, 'h3FFFF); rq(0, 'h5FFFF);
    rq(0, 'h60000); rq(0, 'h6FFFF); rq(0, 'h70000); rq(0, TOP);
    tag = "R7";
    wp_n = 0; part(1, 'h3FFFF, 0); rq(0, 'h20000); rq(1, 0, 0); rq(3, 'h20); wp_n = 1;
    rq(0, 'h20000);
    tag = "R8";
    rq(3, 0); rq(3, 15); rq(3, 16); rq(3, 271); rq(3, 272); rq(3, 'h40000);
    tag = "R10";
    rq(5, 0); rq(7, 'h20);
    tag = "R9";
    rq(4, 0); rq(3, 16); rq(3, 100); rq(1, 0, 0); rq(5, 0); rq(3, 271);
    tag = "R2"; // back-to-back requests
    @(negedge clk);
    req_valid = 1; req_kind = 0; req_addr = 'h100; @(negedge clk);
    req_addr = 'h101; @(negedge clk); req_addr = 'h102; @(negedge clk);
    req_valid = 0;
    tag = "R10"; // mixed stream against the model
    lf = 32'h1ACE5EED;
    for (int n = 0; n < 400; n++) begin
      lf = (lf << 1) ^ (((lf >> 31) ^ (lf >> 21) ^ (lf >> 1) ^ lf) & 1);
      @(negedge clk);
      req_valid = lf[3] | lf[9];
      req_kind  = 3'(lf[14:12] == 3'd4 ? 3'd0 : lf[14:12]);
      req_addr  = lf[15] ? AW'(lf[24:16]) : AW'(lf >> 5);
      req_data  = (AW+1)'(lf >> 2);
      wp_n      = lf[27] | lf[28];
    end
    @(negedge clk); req_valid = 0; wp_n = 1;
    tag = "R1";
    rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    rq(3, 16);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule